// File: doc/BRIEF.md
# Page-Mode ROM Read Controller

This block is a clocked host-side engine that reads bursts from an asynchronous parallel ROM which offers a fast page read. A host hands over a start address and a burst length on a valid/ready request channel. The controller then drives the ROM address, the chip-enable, the output-enable and the bus-width select. It counts wait states, latches the data bus at the end of each wait, and returns every beat on a response strobe, with a flag on the final beat.

The ROM can run as a 16-bit word device or as an 8-bit byte device. In byte mode the lowest address line is borrowed from the top data pin. A page holds 8 words or 16 bytes. The first access of a burst, and the first access after the burst moves into a new page, waits the long random-access time. Every further beat inside the same page waits only the short page time, and only the in-page address bits move. When a burst ends, both enables are released, and no new request is taken until the data bus has had time to float.

Top module: `rom_pm_ctrl`

## Requirements
- R1: After reset, and whenever reset is applied mid-burst, rom_ce_n and rom_oe_n are 1, req_ready is 1 and rsp_valid is 0.
- R2: In word mode (cfg_word_mode=1 at acceptance) rom_word_mode is 1 and rom_lsb_en is 0. rom_addr carries beat address bits [20:0]. rsp_data returns all 16 bus bits.
- R3: In byte mode (cfg_word_mode=0 at acceptance) rom_word_mode is 0 and rom_lsb_en is 1. rom_addr carries beat address bits [21:1] and rom_lsb carries bit [0]. rsp_data is {8'h00, rom_data[7:0]}.
- R4: rom_ce_n and rom_oe_n fall on the accepting clock edge. The first beat is captured, and rsp_valid is high, exactly WAIT_RAND cycles after that edge.
- R5: A beat in the same page as the previous beat is captured WAIT_PAGE cycles after the previous capture. During that wait rom_ce_n, rom_word_mode and rom_addr[20:3] stay unchanged.
- R6: A page is 8 words (beat address bits [2:0]) or 16 bytes (bits [3:0]). A later beat whose in-page offset is 0 waits WAIT_RAND cycles. Beat addresses wrap modulo the address space of the mode.
- R7: A request returns exactly req_len+1 beats at consecutive addresses. rsp_last is high with the final beat only.
- R8: rom_ce_n and rom_oe_n rise on the edge that captures the final beat. req_ready returns exactly WAIT_FLOAT cycles later. Chip enable is never low while idle.
- R9: The bus mode is taken from cfg_word_mode at acceptance. Changes of cfg_word_mode during a burst have no effect on rom_word_mode or on the returned data.
- R10: req_ready is 0 from acceptance until the float wait ends. A request offered during that time is not taken and adds no beats.
- R11: Each wait is the ceiling of its delay divided by CLK_NS, with a minimum of 1. WAIT_RAND is also at least the output-enable lead. The defaults give WAIT_RAND=10, WAIT_PAGE=3 and WAIT_FLOAT=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word_mode | input | 1 | Bus width for the next request: 1 word, 0 byte |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (idle) |
| req_addr | input | WADDR_W+1 | Start beat address, in units of the mode |
| req_len | input | LEN_W | Number of beats minus one |
| rsp_valid | output | 1 | Beat data valid, one cycle per beat |
| rsp_data | output | DATA_W | Beat data |
| rsp_last | output | 1 | Final beat of the burst |
| rom_addr | output | WADDR_W | ROM address lines |
| rom_lsb | output | 1 | Byte-select address line (byte mode) |
| rom_lsb_en | output | 1 | Drive enable for rom_lsb |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_word_mode | output | 1 | ROM bus width select, 1 word |
| rom_data | input | DATA_W | ROM data bus |

## Verification
The assertions assume that the host keeps req_valid, req_addr and req_len steady only around the accepting edge, and that it may change cfg_word_mode at any time. The stimulus therefore drives all inputs half a cycle away from the active edge, and it toggles cfg_word_mode on every cycle of one burst. The ROM model in the bench counts how many cycles the enables, the page address and the full address have been stable. It returns inverted data whenever a wait was too short, so any timing violation shows up as a data mismatch. The bench also lets a stray request stay on the channel during one burst and drops it before the float wait ends.

// File: rtl/rom_pm_pkg.sv
package rom_pm_pkg;

    // Controller phases: waiting for a host request, running ROM beats,
    // or letting the data bus float after a burst.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_FLOAT  = 2'd2
    } ctl_state_e;

    // Per-cycle control handed from the sequencer to the capture stage.
    typedef struct packed {
        logic capture;
        logic last;
        logic word_mode;
    } beat_tag_t;

    // Whole clock cycles needed to cover a delay given in nanoseconds.
    function automatic int unsigned ceil_div(input int unsigned num,
                                             input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned at_least(input int unsigned a,
                                             input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rom_pm_wait_timer.sv
module rom_pm_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    // Counts down from the loaded value; expire marks the edge that ends the wait.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == CNT_W'(1));

    // R11: every wait lasts at least one cycle
    assert_wait_nonzero_R11: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));

endmodule

// File: rtl/rom_pm_addr_gen.sv
module rom_pm_addr_gen #(
    parameter int WADDR_W   = 21,
    parameter int PAGE_BITS = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  logic [WADDR_W:0]   load_addr,
    input  logic               word_mode,
    output logic [WADDR_W-1:0] pin_addr,
    output logic               pin_lsb,
    output logic               pin_lsb_en,
    output logic               next_new_page
);

    localparam int BADDR_W = WADDR_W + 1;

    logic [BADDR_W-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else if (load) begin
            beat_q <= load_addr;
        end else if (step) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    // Pin mapping: word beats sit on the address lines directly; byte beats
    // put their lowest bit on the borrowed select line.
    always_comb begin
        if (word_mode) begin
            pin_addr   = beat_q[WADDR_W-1:0];
            pin_lsb    = 1'b0;
            pin_lsb_en = 1'b0;
        end else begin
            pin_addr   = beat_q[BADDR_W-1:1];
            pin_lsb    = beat_q[0];
            pin_lsb_en = 1'b1;
        end
    end

    // The following beat opens a new page when the in-page field is all ones.
    logic word_page_end;
    logic byte_page_end;
    assign word_page_end = &beat_q[PAGE_BITS-1:0];
    assign byte_page_end = &beat_q[PAGE_BITS:0];
    assign next_new_page = word_mode ? word_page_end : byte_page_end;

    // R5: an in-page step moves only the in-page address lines
    assert_upper_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (step && !next_new_page) |=> $stable(pin_addr[WADDR_W-1:PAGE_BITS]));

    // R7: a new burst and a beat advance never coincide
    assert_load_step_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(load && step));

endmodule

// File: rtl/rom_pm_beat_capture.sv
module rom_pm_beat_capture
    import rom_pm_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  beat_tag_t         tag,
    input  logic [DATA_W-1:0] bus_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_last
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] shaped;

    // Byte mode returns only the low lane; the top data pin is an address then.
    always_comb begin
        if (tag.word_mode) begin
            shaped = bus_data;
        end else begin
            shaped = {{HALF_W{1'b0}}, bus_data[HALF_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_last  <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= tag.capture;
            rsp_last  <= tag.capture && tag.last;
            if (tag.capture) begin
                rsp_data <= shaped;
            end
        end
    end

    // R7: the final-beat flag only accompanies a beat
    assert_last_has_valid_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_last |-> rsp_valid);

    // R3: byte beats carry a cleared upper lane
    assert_byte_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !tag.word_mode) |-> (rsp_data[DATA_W-1:HALF_W] == '0));

endmodule

// File: rtl/rom_pm_ctrl.sv
module rom_pm_ctrl
    import rom_pm_pkg::*;
#(
    parameter int CLK_NS     = 10,
    parameter int T_RAND_NS  = 100,
    parameter int T_PAGE_NS  = 30,
    parameter int T_OE_NS    = 30,
    parameter int T_FLOAT_NS = 20,
    parameter int WADDR_W    = 21,
    parameter int PAGE_BITS  = 3,
    parameter int LEN_W      = 5,
    parameter int DATA_W     = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_word_mode,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [WADDR_W:0]   req_addr,
    input  logic [LEN_W-1:0]   req_len,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               rsp_last,
    output logic [WADDR_W-1:0] rom_addr,
    output logic               rom_lsb,
    output logic               rom_lsb_en,
    output logic               rom_ce_n,
    output logic               rom_oe_n,
    output logic               rom_word_mode,
    input  logic [DATA_W-1:0]  rom_data
);

    localparam int unsigned WAIT_RAND  = at_least(at_least(ceil_div(T_RAND_NS, CLK_NS),
                                                           ceil_div(T_OE_NS, CLK_NS)), 1);
    localparam int unsigned WAIT_PAGE  = at_least(ceil_div(T_PAGE_NS, CLK_NS), 1);
    localparam int unsigned WAIT_FLOAT = at_least(ceil_div(T_FLOAT_NS, CLK_NS), 1);
    localparam int CNT_W = $clog2(at_least(WAIT_RAND, WAIT_FLOAT) + 1);

    localparam logic [CNT_W-1:0] LD_RAND  = CNT_W'(WAIT_RAND);
    localparam logic [CNT_W-1:0] LD_PAGE  = CNT_W'(WAIT_PAGE);
    localparam logic [CNT_W-1:0] LD_FLOAT = CNT_W'(WAIT_FLOAT);

    ctl_state_e         state_q;
    logic [LEN_W-1:0]   beats_left_q;
    logic               mode_q;
    logic               ce_n_q;
    logic               oe_n_q;

    logic               accept;
    logic               timer_load;
    logic [CNT_W-1:0]   timer_val;
    logic               expire;
    logic               step;
    logic               next_new_page;
    beat_tag_t          tag;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Wait selection: long wait to open a page, short wait inside it,
    // float wait after the final beat.
    always_comb begin
        timer_load = 1'b0;
        timer_val  = LD_RAND;
        step       = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    timer_load = 1'b1;
                    timer_val  = LD_RAND;
                end
            end
            ST_ACCESS: begin
                if (expire) begin
                    timer_load = 1'b1;
                    if (beats_left_q == '0) begin
                        timer_val = LD_FLOAT;
                    end else begin
                        step      = 1'b1;
                        timer_val = next_new_page ? LD_RAND : LD_PAGE;
                    end
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            beats_left_q <= '0;
            mode_q       <= 1'b1;
            ce_n_q       <= 1'b1;
            oe_n_q       <= 1'b1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q      <= ST_ACCESS;
                        mode_q       <= cfg_word_mode;
                        beats_left_q <= req_len;
                        ce_n_q       <= 1'b0;
                        oe_n_q       <= 1'b0;
                    end
                end
                ST_ACCESS: begin
                    if (expire) begin
                        if (beats_left_q == '0) begin
                            state_q <= ST_FLOAT;
                            ce_n_q  <= 1'b1;
                            oe_n_q  <= 1'b1;
                        end else begin
                            beats_left_q <= beats_left_q - 1'b1;
                        end
                    end
                end
                ST_FLOAT: begin
                    if (expire) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rom_ce_n      = ce_n_q;
    assign rom_oe_n      = oe_n_q;
    assign rom_word_mode = mode_q;

    assign tag.capture   = (state_q == ST_ACCESS) && expire;
    assign tag.last      = (beats_left_q == '0);
    assign tag.word_mode = mode_q;

    rom_pm_wait_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val (timer_val),
        .expire   (expire)
    );

    rom_pm_addr_gen #(
        .WADDR_W   (WADDR_W),
        .PAGE_BITS (PAGE_BITS)
    ) addr_i (
        .clk           (clk),
        .rst           (rst),
        .load          (accept),
        .step          (step),
        .load_addr     (req_addr),
        .word_mode     (mode_q),
        .pin_addr      (rom_addr),
        .pin_lsb       (rom_lsb),
        .pin_lsb_en    (rom_lsb_en),
        .next_new_page (next_new_page)
    );

    rom_pm_beat_capture #(
        .DATA_W (DATA_W)
    ) cap_i (
        .clk       (clk),
        .rst       (rst),
        .tag       (tag),
        .bus_data  (rom_data),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_last  (rsp_last)
    );

    // Cycles chip enable has been high, saturating; used by the float check.
    logic [CNT_W-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '1;
        end else if (!rom_ce_n) begin
            gap_q <= '0;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R8: idle means standby with the outputs released
    assert_idle_standby_R8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (rom_ce_n && rom_oe_n));

    // R8: chip enable returns only after the float wait
    assert_float_gap_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(rom_ce_n) |-> (gap_q >= LD_FLOAT));

    // R8: the final beat coincides with release of the enables
    assert_last_closes_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_last |-> (rom_ce_n && rom_oe_n && !req_ready));

    // R9: bus width never changes while the ROM is selected
    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!rom_ce_n && $past(!rom_ce_n)) |-> $stable(rom_word_mode));

    // R10: no beat is returned while a new request could be taken
    assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !rsp_valid);

endmodule

// File: tb/rom_pm_ctrl_tb_top.sv
module rom_pm_ctrl_tb_top;

    localparam int CLK_NS = 10;
    localparam int WA     = 21;
    localparam int LW     = 5;
    localparam int DW     = 16;
    localparam int W_RAND  = (100 + CLK_NS - 1) / CLK_NS;
    localparam int W_PAGE  = (30 + CLK_NS - 1) / CLK_NS;
    localparam int W_OE    = (30 + CLK_NS - 1) / CLK_NS;
    localparam int W_FLOAT = (20 + CLK_NS - 1) / CLK_NS;

    // {word_mode, start address, len, expected cycles from accept to final beat}
    localparam logic [35:0] VEC [8] = '{
        {1'b1, 22'h000010, 5'd3,  8'd19},
        {1'b1, 22'h000005, 5'd5,  8'd32},
        {1'b0, 22'h00001C, 5'd6,  8'd35},
        {1'b0, 22'h2ABCDF, 5'd0,  8'd10},
        {1'b1, 22'h1FFFFE, 5'd2,  8'd23},
        {1'b0, 22'h000000, 5'd17, 8'd68},
        {1'b1, 22'h000123, 5'd9,  8'd44},
        {1'b0, 22'h3FFFFF, 5'd1,  8'd20}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_word_mode = 1'b1;
    logic          req_valid = 1'b0;
    logic [WA:0]   req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          rsp_last;
    logic [WA-1:0] rom_addr;
    logic          rom_lsb;
    logic          rom_lsb_en;
    logic          rom_ce_n;
    logic          rom_oe_n;
    logic          rom_word_mode;
    logic [DW-1:0] rom_data;

    int unsigned cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rom_pm_ctrl dut_i (
        .clk           (clk),
        .rst           (rst),
        .cfg_word_mode (cfg_word_mode),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_len       (req_len),
        .rsp_valid     (rsp_valid),
        .rsp_data      (rsp_data),
        .rsp_last      (rsp_last),
        .rom_addr      (rom_addr),
        .rom_lsb       (rom_lsb),
        .rom_lsb_en    (rom_lsb_en),
        .rom_ce_n      (rom_ce_n),
        .rom_oe_n      (rom_oe_n),
        .rom_word_mode (rom_word_mode),
        .rom_data      (rom_data)
    );

    function automatic logic [15:0] word_val(input logic [20:0] w);
        logic [31:0] t;
        t = ({11'd0, w} * 32'h0000_9E37) ^ ({11'd0, w} >> 3);
        return t[15:0] ^ 16'h5AC3;
    endfunction

    function automatic logic [7:0] byte_val(input logic [21:0] b);
        logic [15:0] wv;
        wv = word_val(b[21:1]);
        return b[0] ? wv[15:8] : wv[7:0];
    endfunction

    // ROM model: stability counters updated away from the active edge;
    // data is inverted whenever a required wait has not yet elapsed.
    int cnt_u = 0;
    int cnt_a = 0;
    int cnt_oe = 0;
    logic [19:0] prev_u = '0;
    logic [21:0] prev_a = '0;
    logic        prev_oe = 1'b1;

    always @(negedge clk) begin
        if ({rom_ce_n, rom_word_mode, rom_addr[20:3]} != prev_u) cnt_u <= 0;
        else if (cnt_u < 1000) cnt_u <= cnt_u + 1;
        if ({rom_addr, rom_lsb & rom_lsb_en} != prev_a) cnt_a <= 0;
        else if (cnt_a < 1000) cnt_a <= cnt_a + 1;
        if (rom_oe_n != prev_oe) cnt_oe <= 0;
        else if (cnt_oe < 1000) cnt_oe <= cnt_oe + 1;
        prev_u  <= {rom_ce_n, rom_word_mode, rom_addr[20:3]};
        prev_a  <= {rom_addr, rom_lsb & rom_lsb_en};
        prev_oe <= rom_oe_n;
    end

    always_comb begin
        logic [15:0] v;
        logic good;
        good = !rom_ce_n && !rom_oe_n && (cnt_u >= W_RAND - 1) &&
               (cnt_a >= W_PAGE - 1) && (cnt_oe >= W_OE - 1);
        if (rom_word_mode) v = word_val(rom_addr);
        else               v = {8'hEE, byte_val({rom_addr, rom_lsb})};
        rom_data = good ? v : ~v;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic run_burst(input logic mode, input logic [21:0] addr,
                             input logic [4:0] len, input int exp_lat,
                             input bit hold_req, input bit toggle_cfg);
        int unsigned a0;
        int unsigned exp_t;
        int got;
        logic [21:0] b;
        logic [15:0] exp_d;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cfg_word_mode = mode;
        req_valid = 1'b1;
        req_addr  = addr;
        req_len   = len;
        a0 = cyc + 1;
        @(negedge clk);
        if (hold_req) begin
            req_addr = ~addr;
            req_len  = 5'd7;
        end else begin
            req_valid = 1'b0;
        end
        check(!rom_ce_n && !rom_oe_n, "R4", "enables low after accept", {rom_ce_n, rom_oe_n}, 0);
        check(!req_ready, "R10", "ready low when busy", req_ready, 0);
        check(rom_word_mode == mode, "R9", "mode pin", rom_word_mode, mode);
        if (mode) begin
            check(rom_addr == addr[20:0] && !rom_lsb_en, "R2", "word pins", {rom_lsb_en, rom_addr}, addr[20:0]);
        end else begin
            check(rom_addr == addr[21:1] && rom_lsb == addr[0] && rom_lsb_en, "R3", "byte pins",
                  {rom_lsb_en, rom_lsb, rom_addr}, {1'b1, addr[0], addr[21:1]});
        end
        got = 0;
        exp_t = a0;
        for (int k = 0; k < 400; k++) begin
            if (toggle_cfg) cfg_word_mode = ~cfg_word_mode;
            if (rsp_valid) begin
                b = addr + 22'(got);
                if (got == 0) exp_t = exp_t + W_RAND;
                else if (mode ? (b[2:0] == 3'd0) : (b[3:0] == 4'd0)) exp_t = exp_t + W_RAND;   // R6
                else exp_t = exp_t + W_PAGE;                                                   // R5
                if (mode) exp_d = word_val(b[20:0]);
                else      exp_d = {8'h00, byte_val(b)};
                check(rsp_data == exp_d, mode ? "R2" : "R3", "beat data", rsp_data, exp_d);
                check(cyc == exp_t, (got == 0) ? "R4" : "R5/R6", "beat cycle", cyc, exp_t);
                check(rsp_last == (got == int'(len)), "R7", "last flag", rsp_last, (got == int'(len)));
                got++;
                if (got > int'(len)) break;
            end
            @(negedge clk);
        end
        check(got == int'(len) + 1, "R7", "beat count", got, int'(len) + 1);
        check(cyc - a0 == exp_lat, "R6", "burst length in cycles", cyc - a0, exp_lat);
        check(rom_ce_n && rom_oe_n, "R8", "enables released at last beat", {rom_ce_n, rom_oe_n}, 2'b11);
        check(rom_word_mode == mode, "R9", "mode held through burst", rom_word_mode, mode);
        if (hold_req) req_valid = 1'b0;
        for (int k = 1; k < W_FLOAT; k++) begin
            @(negedge clk);
            check(!req_ready && rom_ce_n, "R8", "float wait", {req_ready, rom_ce_n}, 2'b01);
        end
        @(negedge clk);
        check(req_ready, "R8", "ready after float wait", req_ready, 1);
        if (hold_req) begin
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                check(rom_ce_n && !rsp_valid, "R10", "held request ignored", {rom_ce_n, rsp_valid}, 2'b10);
            end
        end
        cfg_word_mode = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(rom_ce_n && rom_oe_n && req_ready && !rsp_valid, "R1", "reset state",
              {rom_ce_n, rom_oe_n, req_ready, rsp_valid}, 4'b1110);

        for (int i = 0; i < 8; i++) begin
            run_burst(VEC[i][35], VEC[i][34:13], VEC[i][12:8], int'(VEC[i][7:0]), 1'b0, 1'b0);
        end

        // R10: a request left on the channel during a burst
        run_burst(1'b1, 22'h000040, 5'd2, 16, 1'b1, 1'b0);
        // R9: mode input toggling during a byte burst
        run_burst(1'b0, 22'h000033, 5'd4, 22, 1'b0, 1'b1);

        // R1: reset in the middle of a burst
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cfg_word_mode = 1'b1;
        req_valid = 1'b1;
        req_addr  = 22'h000200;
        req_len   = 5'd6;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(rom_ce_n && rom_oe_n && req_ready && !rsp_valid, "R1", "mid-burst reset",
              {rom_ce_n, rom_oe_n, req_ready, rsp_valid}, 4'b1110);
        rst = 1'b0;
        run_burst(1'b1, 22'h000207, 5'd1, 20, 1'b0, 1'b0);

        // R11: derived wait counts are the ceiling values with a floor of one
        check(W_RAND == 10 && W_PAGE == 3 && W_FLOAT == 2, "R11", "wait counts",
              {W_RAND[7:0], W_PAGE[7:0], W_FLOAT[7:0]}, 24'h0A0302);

        summary();
        $finish;
    end

endmodule